// File: doc/BRIEF.md
# GPIO Controller with Routable Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 lines. Software sets an output value and an output-enable (direction) bit for every line and reads back the pin state. Pin inputs are normally passed through a two-flop synchronizer. A per-line bypass bit lets a line that is already synchronous skip the synchronizer.

Every line can raise an interrupt. A per-line polarity bit and a per-line edge bit together select level-low, level-high, falling-edge or rising-edge detection. A mask bit gates each line. A byte-wide map field per line steers the line to one of `NUM_IRQ` interrupt outputs, or to none. Each interrupt output is registered and is the OR of every unmasked, triggering line routed to it.

All registers are whole 32-bit words with bit n belonging to line n. Reads are combinational from the address, and writes take effect at the clock edge on which the write strobe is high.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset every register reads zero, `pin_oe` and `pin_out` are zero, and `irq_out` is zero.
- R2: The output register at 0x04, direction at 0x08, mask at 0x0C, polarity at 0x10, edge select at 0x14 and bypass at 0x18 read back what was last written. A write to the input register at 0x00 has no effect on any register or output.
- R3: `pin_oe` equals the direction register and `pin_out` equals the output register, one clock after the write.
- R4: With the bypass bit clear, a pin change appears at 0x00 after the second rising clock edge following the change, and not after the first.
- R5: With a line's bypass bit set, 0x00 shows that line's raw pin with no clock delay.
- R6: Level triggering uses edge=0. With polarity=0 a line triggers while it is low, and with polarity=1 while it is high. The routed output stays high on every cycle that the level holds, with one register of delay after the synchronized value.
- R7: Edge triggering uses edge=1. With polarity=0 a line triggers on a falling edge, and with polarity=1 on a rising edge. Each edge gives a single-cycle pulse on the routed output.
- R8: A line whose mask bit is 0 never contributes to any interrupt output.
- R9: Map word 0x20+4k holds lines 4k..4k+3. Line 4k+j uses bits [8j+7:8j]. If bit 7 of the field is set, the line is unrouted. Otherwise bits [6:0] give the output index, and an index of `NUM_IRQ` or above is also unrouted. Map words read back what was written.
- R10: Each interrupt output is the OR of all unmasked, triggering lines routed to it.
- R11: An access to an unmapped offset or to an address with nonzero bits [1:0] reads zero, and a write to such an address is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_wr | input | 1 | Write strobe for the register port |
| acc_addr | input | ADDR_W | Byte address of the register |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from `acc_addr` |
| pin_in | input | NUM_LINES | Raw pin inputs |
| pin_out | output | NUM_LINES | Output values to the pads |
| pin_oe | output | NUM_LINES | Output enables, 1 = drive |
| irq_out | output | NUM_IRQ | Interrupt outputs |

## Verification
The hardest state to reach from the ports is several lines with different trigger modes sharing one output while their masks and map fields change under them. In that state a wrong OR term or a stale edge history shows for only a single cycle.

Directed phases first build each mode on its own line, then fold two lines onto one output. They also step unrouted codes through the map field. A long random phase then rewrites masks, modes, maps and bypass while every pin toggles. A behavioural model compares `irq_out`, the pin controls and a randomly addressed read on every clock.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
   localparam int OFS_DATA  = 'h00;
   localparam int OFS_OUT   = 'h04;
   localparam int OFS_DIR   = 'h08;
   localparam int OFS_MASK  = 'h0C;
   localparam int OFS_POL   = 'h10;
   localparam int OFS_EDGE  = 'h14;
   localparam int OFS_BYP   = 'h18;
   localparam int OFS_MAP   = 'h20;
   localparam int MAP_FIELD_W   = 8;
   localparam int MAP_PER_WORD  = 4;
   localparam int MAX_LINES     = 32;

   // {polarity, edge}
   typedef enum logic [1:0] {
      TRIG_LEVEL_LOW  = 2'b00,
      TRIG_FALL       = 2'b01,
      TRIG_LEVEL_HIGH = 2'b10,
      TRIG_RISE       = 2'b11
   } trig_mode_t;
endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int ADDR_W    = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      acc_wr,
   input  logic [ADDR_W-1:0]         acc_addr,
   input  logic [31:0]               acc_wdata,
   output logic [31:0]               acc_rdata,
   input  logic [NUM_LINES-1:0]      in_i,
   output logic [NUM_LINES-1:0]      out_o,
   output logic [NUM_LINES-1:0]      dir_o,
   output logic [NUM_LINES-1:0]      mask_o,
   output logic [NUM_LINES-1:0]      pol_o,
   output logic [NUM_LINES-1:0]      edge_o,
   output logic [NUM_LINES-1:0]      byp_o,
   output logic [NUM_LINES-1:0][7:0] map_o
);
   localparam int WORD_W = ADDR_W - 2;

   logic [WORD_W-1:0] word;
   logic              aligned;

   assign word    = acc_addr[ADDR_W-1:2];
   assign aligned = (acc_addr[1:0] == 2'b00);

   function automatic logic sel(input logic [WORD_W-1:0] w, input logic al, input int ofs);
      return al && (w == WORD_W'(ofs / 4));
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_o  <= '0;
         dir_o  <= '0;
         mask_o <= '0;
         pol_o  <= '0;
         edge_o <= '0;
         byp_o  <= '0;
         map_o  <= '0;
      end else if (acc_wr) begin
         if (sel(word, aligned, OFS_OUT))  out_o  <= acc_wdata[NUM_LINES-1:0];
         if (sel(word, aligned, OFS_DIR))  dir_o  <= acc_wdata[NUM_LINES-1:0];
         if (sel(word, aligned, OFS_MASK)) mask_o <= acc_wdata[NUM_LINES-1:0];
         if (sel(word, aligned, OFS_POL))  pol_o  <= acc_wdata[NUM_LINES-1:0];
         if (sel(word, aligned, OFS_EDGE)) edge_o <= acc_wdata[NUM_LINES-1:0];
         if (sel(word, aligned, OFS_BYP))  byp_o  <= acc_wdata[NUM_LINES-1:0];
         for (int l = 0; l < NUM_LINES; l++) begin
            if (sel(word, aligned, OFS_MAP + 4 * (l / MAP_PER_WORD)))
               map_o[l] <= acc_wdata[MAP_FIELD_W*(l%MAP_PER_WORD) +: MAP_FIELD_W];
         end
      end
   end

   always_comb begin
      acc_rdata = '0;
      if (sel(word, aligned, OFS_DATA)) acc_rdata = 32'(in_i);
      if (sel(word, aligned, OFS_OUT))  acc_rdata = 32'(out_o);
      if (sel(word, aligned, OFS_DIR))  acc_rdata = 32'(dir_o);
      if (sel(word, aligned, OFS_MASK)) acc_rdata = 32'(mask_o);
      if (sel(word, aligned, OFS_POL))  acc_rdata = 32'(pol_o);
      if (sel(word, aligned, OFS_EDGE)) acc_rdata = 32'(edge_o);
      if (sel(word, aligned, OFS_BYP))  acc_rdata = 32'(byp_o);
      for (int l = 0; l < NUM_LINES; l++) begin
         if (sel(word, aligned, OFS_MAP + 4 * (l / MAP_PER_WORD)))
            acc_rdata[MAP_FIELD_W*(l%MAP_PER_WORD) +: MAP_FIELD_W] = map_o[l];
      end
   end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] pin_i,
   input  logic [NUM_LINES-1:0] byp_i,
   output logic [NUM_LINES-1:0] sync_o,
   output logic [NUM_LINES-1:0] cur_o,
   output logic [NUM_LINES-1:0] prev_o
);
   logic [NUM_LINES-1:0] stage1_q;
   logic [NUM_LINES-1:0] stage2_q;
   logic [NUM_LINES-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1_q <= '0;
         stage2_q <= '0;
         prev_q   <= '0;
      end else begin
         stage1_q <= pin_i;
         stage2_q <= stage1_q;
         prev_q   <= cur_o;
      end
   end

   for (genvar l = 0; l < NUM_LINES; l++) begin : g_sel
      assign cur_o[l] = byp_i[l] ? pin_i[l] : stage2_q[l];
   end

   assign sync_o = stage2_q;
   assign prev_o = prev_q;
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES = 32
) (
   input  logic [NUM_LINES-1:0] cur_i,
   input  logic [NUM_LINES-1:0] prev_i,
   input  logic [NUM_LINES-1:0] mask_i,
   input  logic [NUM_LINES-1:0] pol_i,
   input  logic [NUM_LINES-1:0] edge_i,
   output logic [NUM_LINES-1:0] hit_o
);
   for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      trig_mode_t mode;
      logic       raw;

      assign mode = trig_mode_t'({pol_i[l], edge_i[l]});

      always_comb begin
         case (mode)
            TRIG_LEVEL_LOW:  raw = ~cur_i[l];
            TRIG_LEVEL_HIGH: raw = cur_i[l];
            TRIG_FALL:       raw = prev_i[l] & ~cur_i[l];
            TRIG_RISE:       raw = ~prev_i[l] & cur_i[l];
            default:         raw = 1'b0;
         endcase
      end

      assign hit_o[l] = mask_i[l] & raw;
   end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
   parameter int NUM_LINES = 32,
   parameter int NUM_IRQ   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_LINES-1:0]      hit_i,
   input  logic [NUM_LINES-1:0][7:0] map_i,
   output logic [NUM_IRQ-1:0]        irq_o
);
   logic [NUM_IRQ-1:0] any_hit;

   for (genvar o = 0; o < NUM_IRQ; o++) begin : g_out
      always_comb begin
         any_hit[o] = 1'b0;
         for (int l = 0; l < NUM_LINES; l++) begin
            if (!map_i[l][7] && (map_i[l][6:0] == 7'(o)))
               any_hit[o] = any_hit[o] | hit_i[l];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o[o] <= 1'b0;
         else        irq_o[o] <= any_hit[o];
      end
   end
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
   import gpio_irq_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int NUM_IRQ   = 4,
   parameter int ADDR_W    = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_wr,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic [31:0]          acc_wdata,
   output logic [31:0]          acc_rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pin_out,
   output logic [NUM_LINES-1:0] pin_oe,
   output logic [NUM_IRQ-1:0]   irq_out
);
   localparam int MAP_WORDS = (NUM_LINES + MAP_PER_WORD - 1) / MAP_PER_WORD;
   localparam int ADDR_END  = OFS_MAP + 4 * MAP_WORDS;

   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("NUM_LINES must lie in 1..32");
   end
   if (NUM_IRQ < 1 || NUM_IRQ > 127) begin : g_bad_irq
      $error("NUM_IRQ must lie in 1..127");
   end
   if (ADDR_W < 3 || (1 << ADDR_W) < ADDR_END) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NUM_LINES-1:0]      mask_q, pol_q, edge_q, byp_q;
   logic [NUM_LINES-1:0][7:0] map_q;
   logic [NUM_LINES-1:0]      sync_q, cur_v, prev_v, hit_v;

   gpio_regfile #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc_wr   (acc_wr),
      .acc_addr (acc_addr),
      .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata),
      .in_i     (cur_v),
      .out_o    (pin_out),
      .dir_o    (pin_oe),
      .mask_o   (mask_q),
      .pol_o    (pol_q),
      .edge_o   (edge_q),
      .byp_o    (byp_q),
      .map_o    (map_q)
   );

   gpio_in_sync #(.NUM_LINES(NUM_LINES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_i (pin_in),
      .byp_i (byp_q),
      .sync_o(sync_q),
      .cur_o (cur_v),
      .prev_o(prev_v)
   );

   gpio_trigger #(.NUM_LINES(NUM_LINES)) u_trig (
      .cur_i (cur_v),
      .prev_i(prev_v),
      .mask_i(mask_q),
      .pol_i (pol_q),
      .edge_i(edge_q),
      .hit_o (hit_v)
   );

   gpio_irq_route #(.NUM_LINES(NUM_LINES), .NUM_IRQ(NUM_IRQ)) u_route (
      .clk  (clk),
      .rst_n(rst_n),
      .hit_i(hit_v),
      .map_i(map_q),
      .irq_o(irq_out)
   );
endmodule

// File: rtl/gpio_irq_router_sva.sv
module gpio_irq_router_sva #(
   parameter int NUM_LINES = 32,
   parameter int NUM_IRQ   = 4,
   parameter int ADDR_W    = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 acc_wr,
   input logic [ADDR_W-1:0]    acc_addr,
   input logic [31:0]          acc_wdata,
   input logic [NUM_LINES-1:0] pin_in,
   input logic [NUM_LINES-1:0] pin_out,
   input logic [NUM_LINES-1:0] pin_oe,
   input logic [NUM_IRQ-1:0]   irq_out,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] sync_q
);
   logic [1:0] warm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          warm <= '0;
      else if (warm != 2'd2) warm <= warm + 2'd1;
   end

   p_oe_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_addr == ADDR_W'(8)) |=> (pin_oe == $past(acc_wdata[NUM_LINES-1:0])));

   p_out_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_addr == ADDR_W'(4)) |=> (pin_out == $past(acc_wdata[NUM_LINES-1:0])));

   p_sync_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (warm == 2'd2) |-> (sync_q == $past(pin_in, 2)));

   p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out != '0) |-> ($past(mask_q) != '0));

   p_data_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_addr == ADDR_W'(0)) |=> ($stable(pin_oe) && $stable(pin_out) && $stable(mask_q)));
endmodule

bind gpio_irq_router gpio_irq_router_sva #(
   .NUM_LINES(NUM_LINES),
   .NUM_IRQ  (NUM_IRQ),
   .ADDR_W   (ADDR_W)
) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_wr   (acc_wr),
   .acc_addr (acc_addr),
   .acc_wdata(acc_wdata),
   .pin_in   (pin_in),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .irq_out  (irq_out),
   .mask_q   (mask_q),
   .sync_q   (sync_q)
);

// File: tb/gpio_irq_router_bench.sv
module gpio_irq_router_bench;
   localparam int N  = 32;
   localparam int NI = 4;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_wr = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [31:0]   acc_wdata = '0;
   logic [31:0]   acc_rdata;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out, pin_oe;
   logic [NI-1:0] irq_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit cmp_on = 0;

   always #10 clk = ~clk;

   gpio_irq_router #(.NUM_LINES(N), .NUM_IRQ(NI), .ADDR_W(AW)) u_gpio_irq_router (
      .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_addr(acc_addr),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
   );

   // ---------------- behavioural reference ----------------
   logic [31:0]   m_out, m_dir, m_mask, m_pol, m_edge, m_byp;
   logic [7:0]    m_map [N];
   logic [N-1:0]  m_s1, m_s2, m_prev;
   logic [NI-1:0] m_irq;

   function automatic logic [N-1:0] m_cur();
      logic [N-1:0] r;
      for (int l = 0; l < N; l++) r[l] = m_byp[l] ? pin_in[l] : m_s2[l];
      return r;
   endfunction

   function automatic logic [NI-1:0] m_next_irq();
      logic [NI-1:0] r;
      logic [N-1:0]  c;
      bit            t;
      int            idx;
      r = '0;
      c = m_cur();
      for (int l = 0; l < N; l++) begin
         if (!m_edge[l]) t = m_pol[l] ? c[l] : !c[l];
         else            t = m_pol[l] ? (c[l] && !m_prev[l]) : (!c[l] && m_prev[l]);
         idx = int'(m_map[l][6:0]);
         if (m_mask[l] && !m_map[l][7] && idx < NI && t) r[idx] = 1'b1;
      end
      return r;
   endfunction

   function automatic logic [31:0] m_read(input int a);
      logic [31:0] r;
      r = '0;
      case (a)
         'h00: r = 32'(m_cur());
         'h04: r = m_out;
         'h08: r = m_dir;
         'h0C: r = m_mask;
         'h10: r = m_pol;
         'h14: r = m_edge;
         'h18: r = m_byp;
         default: begin
            for (int l = 0; l < N; l++)
               if (a == 'h20 + 4 * (l / 4)) r[8*(l%4) +: 8] = m_map[l];
         end
      endcase
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_out <= '0; m_dir <= '0; m_mask <= '0; m_pol <= '0; m_edge <= '0; m_byp <= '0;
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_irq <= '0;
         for (int l = 0; l < N; l++) m_map[l] <= '0;
      end else begin
         m_s1   <= pin_in;
         m_s2   <= m_s1;
         m_prev <= m_cur();
         m_irq  <= m_next_irq();
         if (acc_wr) begin
            case (int'(acc_addr))
               'h04: m_out  <= acc_wdata;
               'h08: m_dir  <= acc_wdata;
               'h0C: m_mask <= acc_wdata;
               'h10: m_pol  <= acc_wdata;
               'h14: m_edge <= acc_wdata;
               'h18: m_byp  <= acc_wdata;
               default: ;
            endcase
            for (int l = 0; l < N; l++)
               if (int'(acc_addr) == 'h20 + 4 * (l / 4)) m_map[l] <= acc_wdata[8*(l%4) +: 8];
         end
      end
   end

   // ---------------- checking ----------------
   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk("R3 pin_oe", 32'(pin_oe), m_dir);
         chk("R3 pin_out", 32'(pin_out), m_out);
         chk("R6/R7/R8/R9/R10 irq_out", 32'(irq_out), 32'(m_irq));
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      acc_wr = 1'b1; acc_addr = AW'(a); acc_wdata = d;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
      @(negedge clk);
      acc_addr = AW'(a);
      #1;
      chk(req, acc_rdata, exp);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_irq(input int o, input int cycles, output int n);
      n = 0;
      repeat (cycles) begin
         @(negedge clk); #2;
         n += int'(irq_out[o]);
      end
   endtask

   task automatic irq_now(input string req, input int o, input logic exp);
      @(negedge clk); #2;
      chk(req, 32'(irq_out[o]), 32'(exp));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cmp_on = 1;

      // R1 reset state
      for (int a = 0; a < 'h40; a += 4) rd_chk("R1 reset read", a, 32'h0);
      chk("R1 irq_out reset", 32'(irq_out), 32'h0);
      chk("R1 pin_oe reset", 32'(pin_oe), 32'h0);

      // R2 / R3 readback
      wr('h04, 32'hDEAD_BEEF); wr('h08, 32'h0F0F_00FF);
      rd_chk("R2 out", 'h04, 32'hDEAD_BEEF);
      rd_chk("R2 dir", 'h08, 32'h0F0F_00FF);
      chk("R3 pin_out direct", 32'(pin_out), 32'hDEAD_BEEF);
      chk("R3 pin_oe direct", 32'(pin_oe), 32'h0F0F_00FF);
      wr('h10, 32'h1234_5678); rd_chk("R2 pol", 'h10, 32'h1234_5678);
      wr('h14, 32'h8765_4321); rd_chk("R2 edge", 'h14, 32'h8765_4321);
      wr('h10, 0); wr('h14, 0);
      wr('h00, 32'hFFFF_FFFF);
      rd_chk("R2 data write ignored", 'h00, 32'h0);
      rd_chk("R2 out after data write", 'h04, 32'hDEAD_BEEF);
      wr('h3C, 32'hA1B2_C3D4); rd_chk("R9 map readback", 'h3C, 32'hA1B2_C3D4);

      // R11 misaligned / unmapped
      wr('h05, 32'h1111_1111);
      rd_chk("R11 misaligned write ignored", 'h04, 32'hDEAD_BEEF);
      rd_chk("R11 misaligned read", 'h06, 32'h0);
      rd_chk("R11 unmapped 0x1C", 'h1C, 32'h0);
      rd_chk("R11 unmapped 0x40", 'h40, 32'h0);
      rd_chk("R11 unmapped 0xFC", 'hFC, 32'h0);

      // R4 two-flop delay
      @(negedge clk); pin_in = 32'h0000_00A5; acc_addr = AW'(0); #1;
      chk("R4 no change same cycle", acc_rdata, 32'h0);
      @(negedge clk); #1; chk("R4 not after first edge", acc_rdata, 32'h0);
      @(negedge clk); #1; chk("R4 visible after second edge", acc_rdata, 32'h0000_00A5);

      // R5 bypass
      wr('h18, 32'hFFFF_FFFF);
      @(negedge clk); pin_in = 32'h0000_3C00; acc_addr = AW'(0); #1;
      chk("R5 bypass immediate", acc_rdata, 32'h0000_3C00);
      wr('h18, 0); pin_in = '0; idle(4);

      // interrupt configuration
      wr('h20, 32'h0280_8080);            // line3 -> out2
      wr('h24, 32'h8080_0180);            // line5 -> out1
      wr('h28, 32'h8080_0300);            // line8 -> out0, line9 -> out3
      wr('h10, (1 << 3) | (1 << 8));
      wr('h14, (1 << 3) | (1 << 5));
      @(negedge clk); pin_in = (1 << 5) | (1 << 9);
      idle(4);
      wr('h0C, (1 << 3) | (1 << 5) | (1 << 8) | (1 << 9));
      idle(3);
      chk("R10 all quiet", 32'(irq_out), 32'h0);

      // R7 rising
      @(negedge clk); pin_in[3] = 1'b1;
      count_irq(2, 8, n); chk("R7 rising one pulse", 32'(n), 32'd1);
      count_irq(2, 5, n); chk("R7 held high no pulse", 32'(n), 32'd0);
      // R7 falling
      @(negedge clk); pin_in[5] = 1'b0;
      count_irq(1, 8, n); chk("R7 falling one pulse", 32'(n), 32'd1);
      // R6 level high
      @(negedge clk); pin_in[8] = 1'b1;
      idle(3);
      count_irq(0, 5, n); chk("R6 level high held", 32'(n), 32'd5);
      @(negedge clk); pin_in[8] = 1'b0;
      idle(3); irq_now("R6 level high released", 0, 1'b0);
      // R6 level low
      @(negedge clk); pin_in[9] = 1'b0;
      idle(3);
      count_irq(3, 5, n); chk("R6 level low held", 32'(n), 32'd5);
      @(negedge clk); pin_in[9] = 1'b1;
      idle(3); irq_now("R6 level low released", 3, 1'b0);

      // R8 mask
      wr('h0C, (1 << 3) | (1 << 5) | (1 << 9));
      @(negedge clk); pin_in[8] = 1'b1;
      idle(3);
      count_irq(0, 5, n); chk("R8 masked line silent", 32'(n), 32'd0);
      wr('h0C, (1 << 3) | (1 << 5) | (1 << 8) | (1 << 9));

      // R9 unrouted codes
      wr('h28, 32'h8080_0380);
      idle(2); chk("R9 top bit unrouted", 32'(irq_out), 32'h0);
      wr('h28, 32'h8080_0306);
      idle(2); chk("R9 index out of range", 32'(irq_out), 32'h0);
      wr('h28, 32'h8080_0301);
      idle(2); irq_now("R9 routed to out1", 1, 1'b1);

      // R10 OR of two lines on out1
      wr('h28, 32'h8080_0101);
      @(negedge clk); pin_in[8] = 1'b0; pin_in[9] = 1'b1;
      idle(3); irq_now("R10 none active", 1, 1'b0);
      @(negedge clk); pin_in[9] = 1'b0;
      idle(3); irq_now("R10 line9 only", 1, 1'b1);
      @(negedge clk); pin_in[8] = 1'b1;
      idle(3); irq_now("R10 both", 1, 1'b1);
      @(negedge clk); pin_in[9] = 1'b1;
      idle(3); irq_now("R10 line8 only", 1, 1'b1);
      @(negedge clk); pin_in[8] = 1'b0;
      idle(3); irq_now("R10 none again", 1, 1'b0);

      // random phase against the model
      for (int i = 0; i < 4000; i++) begin
         int a;
         int sel;
         @(negedge clk);
         if ($urandom_range(0, 3) == 0) pin_in = $urandom();
         else pin_in[$urandom_range(0, N - 1)] ^= 1'b1;
         sel = $urandom_range(0, 15);
         a = (sel < 15) ? sel * 4 : 'h40;
         acc_addr = AW'(a);
         acc_wr = ($urandom_range(0, 5) == 0);
         acc_wdata = $urandom();
         if (acc_wr && (a == 'h20 || a == 'h24 || a == 'h28 || a == 'h2C))
            acc_wdata = acc_wdata & 32'h8383_8383;
         #1;
         chk("R2/R9/R11 random read", acc_rdata, m_read(a));
      end
      @(negedge clk); acc_wr = 1'b0;
      idle(3);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule